// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned `WIDTH`-bit operands over `WIDTH` clock cycles and uses a single `WIDTH`-bit adder. It does not build an array of adders. A double-width accumulator holds the growing partial product in its high half and the not-yet-consumed multiplier bits in its low half.

On every step the block inspects the accumulator's lowest bit. If that bit is set, the multiplicand is added to the high half. The adder's carry-out and the whole accumulator then move one place to the right, and the carry lands in the top bit. After `WIDTH` steps the accumulator holds the full `2*WIDTH`-bit product.

A pulse on `start` latches the operands and the mode. `busy` stays high while the steps run. `done` pulses for one cycle when the result is ready.

A sign-magnitude mode treats each operand's top bit as a sign and the remaining bits as a magnitude. The block multiplies the magnitudes with the same datapath. It places the XOR of the two signs in the result's top bit.

Top module: `seq_mult`

## Requirements
- R1: While and after reset, with no start seen, `busy`, `done` and `product` are all zero.
- R2: A `start` that is high at a rising edge while the block is not busy is accepted. `busy` is high from the next cycle onward.
- R3: In unsigned mode (`sign_mode`=0), `product` equals `multiplicand` × `multiplier` as a `2*WIDTH`-bit unsigned value. This includes 6 × 13 = 78 and 15 × 13 = 195 for `WIDTH`=4.
- R4: `done` is high for exactly one cycle, beginning `WIDTH` rising edges after the accepting edge. `busy` falls in that same cycle and is never high together with `done`.
- R5: A `start` asserted while `busy` is high is ignored. The running operation keeps its timing and its result.
- R6: Changes on `multiplicand`, `multiplier` and `sign_mode` after the accepting edge do not affect the result.
- R7: In sign-magnitude mode (`sign_mode`=1), bit `2*WIDTH-1` of `product` is the XOR of the operands' bit `WIDTH-1`. This holds even when the magnitude is zero. Bits `2*WIDTH-2:0` equal the unsigned product of the operands' bits `WIDTH-2:0`.
- R8: `product` holds its value after `done` until the next `start` is accepted.
- R9: A step whose tested bit is 0 adds nothing and produces a zero carry. A step that adds produces a carry-out, and that carry enters the product's top bit, for example 15 × 15 = 225 for `WIDTH`=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| sign_mode | input | 1 | 0: unsigned operands, 1: sign-magnitude operands |
| multiplicand | input | WIDTH | Multiplicand operand |
| multiplier | input | WIDTH | Multiplier operand |
| busy | output | 1 | Add/shift steps in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Result, held until the next accepted start |

## Verification
With `WIDTH`=4, every pair of operand values is run in both modes. The unsigned sweep separates correct carry handling (products above 2^WIDTH, all-ones operands) from cases that never carry. The sign-magnitude sweep covers all four sign combinations, including zero magnitudes, so a sign derived from the product rather than the operands would show up. Every operation also scrambles the inputs and pulses `start` while busy, so any leak of live inputs or any restart would appear in the result or in the `done` timing.

// File: rtl/seq_mult_pkg.sv
// Shared types for the sequential multiplier.
// Assumes nothing beyond a single clock domain.
package seq_mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mult_state_e;
endpackage

// File: rtl/seq_mult_ctrl.sv
// Sequencer: accepts a start when not running, issues WIDTH step strobes,
// then raises done for one cycle. Assumes WIDTH >= 2.
module seq_mult_ctrl
    import seq_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    mult_state_e        state_q;
    logic [CNT_W-1:0]   left_q;

    assign busy = (state_q == ST_RUN);
    assign done = (state_q == ST_DONE);
    assign load = start && (state_q != ST_RUN);
    assign step = busy;

    // State and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else if (load) begin
            state_q <= ST_RUN;
            left_q  <= CNT_W'(WIDTH - 1);
        end else if (step) begin
            left_q  <= left_q - 1'b1;
            if (left_q == '0) state_q <= ST_DONE;
        end else if (state_q == ST_DONE) begin
            state_q <= ST_IDLE;
        end
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_ends_in_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_last_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left_q == '0) |=> !busy);
    p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && left_q != '0) |=> (busy && left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/seq_mult_opsel.sv
// Operand conditioning: in sign-magnitude mode strips the sign bits,
// zero-extends the magnitudes and forms the result sign; otherwise it
// passes the operands through. Purely combinational. Assumes WIDTH >= 2.
module seq_mult_opsel #(
    parameter int WIDTH = 8
) (
    input  logic             sign_mode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             res_sign
);
    // Select magnitudes and the result sign.
    always_comb begin
        if (sign_mode) begin
            mag_a    = {1'b0, op_a[WIDTH-2:0]};
            mag_b    = {1'b0, op_b[WIDTH-2:0]};
            res_sign = op_a[WIDTH-1] ^ op_b[WIDTH-1];
        end else begin
            mag_a    = op_a;
            mag_b    = op_b;
            res_sign = 1'b0;
        end
    end
endmodule

// File: rtl/seq_mult_datapath.sv
// Accumulator datapath: a 2*WIDTH shift register (partial product high,
// multiplier low), one WIDTH-bit adder and a carry that is shifted into
// the top bit on every step. Assumes load and step are never both high.
module seq_mult_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               mode_in,
    input  logic               sign_in,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0]    acc_q;
    logic [WIDTH-1:0] mcand_q;
    logic             mode_q;
    logic             sign_q;
    logic [WIDTH:0]   sum;
    logic             carry;

    // Conditional add of the multiplicand into the high half.
    always_comb begin
        sum   = {1'b0, acc_q[PW-1:WIDTH]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
        carry = sum[WIDTH];
    end

    // Load operands, or add-then-shift through the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
            mode_q  <= 1'b0;
            sign_q  <= 1'b0;
        end else if (load) begin
            acc_q   <= {{WIDTH{1'b0}}, mplier_in};
            mcand_q <= mcand_in;
            mode_q  <= mode_in;
            sign_q  <= sign_in;
        end else if (step) begin
            acc_q   <= {carry, sum[WIDTH-1:0], acc_q[WIDTH-1:1]};
        end
    end

    assign product = mode_q ? {sign_q, acc_q[PW-2:0]} : acc_q;

    p_no_carry_on_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !acc_q[0]) |-> !carry);
    p_upper_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q[PW-1:WIDTH] == '0));
    p_mcand_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(mcand_q) && $stable(mode_q) && $stable(sign_q));
    p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(acc_q));
endmodule

// File: rtl/seq_mult.sv
// Top level of the sequential shift-add multiplier: operand conditioning,
// sequencer and accumulator datapath. Result is valid while done is high
// and stays until the next accepted start. Assumes WIDTH >= 2.
module seq_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sign_mode,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic             load;
    logic             step;
    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic             res_sign;

    seq_mult_opsel #(.WIDTH(WIDTH)) opsel_i (
        .sign_mode (sign_mode),
        .op_a      (multiplicand),
        .op_b      (multiplier),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .res_sign  (res_sign)
    );

    seq_mult_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    seq_mult_datapath #(.WIDTH(WIDTH)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mode_in   (sign_mode),
        .sign_in   (res_sign),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .product   (product)
    );

    p_busy_done_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: tb/seq_mult_tb_top.sv
`timescale 1ns/1ps
// Exhaustive bench for WIDTH=4 in both modes.
module seq_mult_tb_top;
    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sign_mode = 1'b0;
    logic [W-1:0]  multiplicand = '0;
    logic [W-1:0]  multiplier = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    seq_mult #(.WIDTH(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .sign_mode    (sign_mode),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation with input scrambling and a stray start while busy.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic mode, input string tag);
        logic [PW-1:0] exp;
        if (!mode) begin
            exp = PW'(a) * PW'(b);
        end else begin
            exp = PW'(a[W-2:0]) * PW'(b[W-2:0]);
            exp[PW-1] = a[W-1] ^ b[W-1];
        end
        @(negedge clk);
        multiplicand = a; multiplier = b; sign_mode = mode; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2 busy after start", {62'd0, busy, done}, 64'd2);
        multiplicand = ~a; multiplier = b + 1'b1; sign_mode = ~mode;   // R6 scramble
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            check(busy && !done, "R4 no early done", {62'd0, busy, done}, 64'd2);
            start = (i == 1);                                          // R5 stray start
        end
        @(negedge clk);
        start = 1'b0;
        check(done && !busy, "R4 done after WIDTH steps", {62'd0, busy, done}, 64'd1);
        check(product == exp, tag, 64'(product), 64'(exp));
        @(negedge clk);
        check(!done, "R4 done lasts one cycle", {63'd0, done}, 64'd0);
        check(product == exp, "R8 product held", 64'(product), 64'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && product == '0, "R1 reset state",
              64'(product), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && product == '0, "R1 idle after reset",
              64'(product), 64'd0);
        run_op(4'd6,  4'd13, 1'b0, "R3 6x13=78");
        run_op(4'd15, 4'd13, 1'b0, "R3 R9 15x13=195");
        run_op(4'd15, 4'd15, 1'b0, "R9 carry 15x15=225");
        run_op(4'b1000, 4'b0101, 1'b1, "R7 zero magnitude sign");
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(W'(a), W'(b), 1'b0, "R3 R5 R6 unsigned sweep");
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(W'(a), W'(b), 1'b1, "R7 R5 R6 sign-magnitude sweep");
        repeat (3) @(negedge clk);
        check(!busy && !done, "R8 stays idle", {62'd0, busy, done}, 64'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule